// File: doc/BRIEF.md
# SD Host Command Issue Register

This block is the command-issue front end of an SD/MMC host controller. Software programs a 32-bit argument and a command control word through a small memory-mapped window. Setting the start bit hands a command request to a simplified card-side port. The request carries the command index, the argument, and three qualifiers: response wanted, long (136-bit) response, and application-specific command. Shifting the command onto the CMD wire and generating CRC7 are handled elsewhere. The card side answers with up to four 32-bit response words and an outcome code.

The block stores the response words and reports the outcome on four status outputs. It also records which command produced the latest response. A self-clearing reset bit in the command word returns the whole command path to its idle, all-zero state after a fixed number of cycles. While a command is outstanding, the request on the card port stays frozen, and ordinary register writes are dropped.

Top module: `sd_cmd_issue`

## Requirements
- R1: A write to byte offset 4 stores the argument, which reads back at offset 4. A write to offset 0 stores the command fields: index in bits [5:0], response wanted in bit 6, long response in bit 7, application command in bit 8. These read back in the same bits at offset 0.
- R2: A write to offset 0 with bit 9 set and bit 10 clear, made while idle, raises cmd_req_valid on the next cycle. The card port then shows the written index, qualifiers and the stored argument.
- R3: cmd_req_valid and every request field stay constant until cmd_req_ready is seen. Bit 9 at offset 0 reads 1 during that time and reads 0 from the cycle after acceptance.
- R4: While a command is outstanding, writes to offset 0 without bit 10, and writes to offset 4, change nothing.
- R5: When a command without the response-wanted bit is accepted, the next cycle shows only the sent flag. No outcome flag is set, and the response words are unchanged.
- R6: When rsp_valid arrives for a command awaiting a response, the next cycle shows the sent flag and exactly one outcome flag. rsp_code 0 means CRC ok, 1 means CRC fail, and 2 or 3 means timeout.
- R7: For a short response with CRC ok, only the word at offset 8 is loaded, from rsp_data[31:0]. The words at offsets 12, 16 and 20 keep their values.
- R8: For a long response with CRC ok, offsets 8, 12, 16 and 20 receive rsp_data[31:0], [63:32], [95:64] and [127:96]. Offset 8 therefore holds the least significant word and offset 20 the most significant.
- R9: A CRC-fail or timeout outcome leaves all four response words unchanged.
- R10: Offset 24 reads the index of the last command that received a response (CRC ok or CRC fail) in bits [5:0], and its application flag in bit 6. A timeout does not update it.
- R11: Starting a new command clears all four status flags.
- R12: Writing offset 0 with bit 10 set is accepted even while a command is outstanding, and it aborts that command. Bit 10 then reads 1 for RST_CYCLES (default 4) cycles and 0 afterwards. During that time there is no request, writes are ignored, and the reset leaves every register and status flag at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cmd_req_valid | output | 1 | Command request to the card side |
| cmd_req_ready | input | 1 | Card side accepts the request |
| cmd_req_index | output | 6 | Command index |
| cmd_req_arg | output | 32 | Command argument |
| cmd_req_need_rsp | output | 1 | A response is expected |
| cmd_req_long | output | 1 | The response is 136 bits long |
| cmd_req_app | output | 1 | Application-specific command |
| rsp_valid | input | 1 | Response outcome is present |
| rsp_code | input | 2 | 0 CRC ok, 1 CRC fail, 2 or 3 timeout |
| rsp_data | input | 128 | Response words, least significant word in [31:0] |
| st_sent | output | 1 | Command has completed |
| st_rsp_timeout | output | 1 | Response timed out |
| st_rsp_crc_fail | output | 1 | Response CRC failed |
| st_rsp_crc_ok | output | 1 | Response received with good CRC |

## Verification
A control state stuck in the wrong place shows up at once on the card port. Either a request appears with no start, or a request drops or changes before acceptance. These faults are visible in the cycle after the offending edge. Wrong capture steering appears at the response word readback on the next read: the wrong words change, the long ordering is swapped, or words are loaded on a failed outcome. A broken reset counter shows as a reset bit that clears one cycle early or late, or as leftover argument, response, last-index or flag values once the bit falls.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int REG_AW   = 5;
  localparam int WORD_W   = 32;
  localparam int RSP_WORDS = 4;
  localparam int IDX_W    = 6;

  localparam int OFS_CMD  = 0;
  localparam int OFS_ARG  = 4;
  localparam int OFS_RSP  = 8;
  localparam int OFS_LAST = 24;

  localparam int BIT_NEED = 6;
  localparam int BIT_LONG = 7;
  localparam int BIT_APP  = 8;
  localparam int BIT_GO   = 9;
  localparam int BIT_RST  = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RST  = 2'd3
  } cmd_state_e;

  localparam logic [1:0] CODE_OK   = 2'd0;
  localparam logic [1:0] CODE_FAIL = 2'd1;

  typedef struct packed {
    logic             app;
    logic             long_rsp;
    logic             need_rsp;
    logic [IDX_W-1:0] idx;
  } cmd_fields_t;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          arg_wr,
  input  logic [DW-1:0] wdata,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [1:0]    rsp_code,
  output cmd_fields_t   fields,
  output logic [DW-1:0] arg,
  output logic          go_bit,
  output logic          rst_busy,
  output logic          pending,
  output logic          req_valid,
  output logic          st_sent,
  output logic          st_to,
  output logic          st_fail,
  output logic          st_ok,
  output logic          clr_all,
  output logic          cap_word,
  output logic          cap_long,
  output logic          cap_last
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  cmd_state_e    state_q, state_d;
  cmd_fields_t   fields_q, fields_d;
  logic [DW-1:0] arg_q, arg_d;
  logic          go_q, go_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    flags_q, flags_d;   // {ok, fail, timeout, sent}

  always_comb begin
    state_d  = state_q;
    fields_d = fields_q;
    arg_d    = arg_q;
    go_d     = go_q;
    cnt_d    = cnt_q;
    flags_d  = flags_q;
    clr_all  = 1'b0;
    cap_word = 1'b0;
    cap_long = 1'b0;
    cap_last = 1'b0;
    if (state_q == ST_RST) begin
      if (cnt_q <= CW'(1)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else if (cmd_wr && wdata[BIT_RST]) begin
      state_d  = ST_RST;
      cnt_d    = CW'(RST_CYCLES);
      fields_d = '0;
      arg_d    = '0;
      go_d     = 1'b0;
      flags_d  = '0;
      clr_all  = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arg_wr) arg_d = wdata;
          if (cmd_wr) begin
            fields_d = wdata[BIT_APP:0];
            if (wdata[BIT_GO]) begin
              go_d    = 1'b1;
              state_d = ST_REQ;
              flags_d = '0;
            end
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            go_d = 1'b0;
            if (fields_q.need_rsp) begin
              state_d = ST_WAIT;
            end else begin
              state_d = ST_IDLE;
              flags_d = 4'b0001;
            end
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            state_d = ST_IDLE;
            if (rsp_code == CODE_OK) begin
              flags_d  = 4'b1001;
              cap_word = 1'b1;
              cap_long = fields_q.long_rsp;
              cap_last = 1'b1;
            end else if (rsp_code == CODE_FAIL) begin
              flags_d  = 4'b0101;
              cap_last = 1'b1;
            end else begin
              flags_d  = 4'b0011;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      fields_q <= '0;
      arg_q    <= '0;
      go_q     <= 1'b0;
      cnt_q    <= '0;
      flags_q  <= '0;
    end else begin
      state_q  <= state_d;
      fields_q <= fields_d;
      arg_q    <= arg_d;
      go_q     <= go_d;
      cnt_q    <= cnt_d;
      flags_q  <= flags_d;
    end
  end

  assign fields    = fields_q;
  assign arg       = arg_q;
  assign go_bit    = go_q;
  assign rst_busy  = (state_q == ST_RST);
  assign pending   = (state_q != ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign st_sent   = flags_q[0];
  assign st_to     = flags_q[1];
  assign st_fail   = flags_q[2];
  assign st_ok     = flags_q[3];
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store #(
  parameter int DW = 32,
  parameter int NW = 4,
  parameter int LW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           cap_word,
  input  logic           cap_long,
  input  logic           cap_last,
  input  logic [NW*DW-1:0] data_in,
  input  logic [LW-1:0]  last_in,
  output logic [NW*DW-1:0] words,
  output logic [LW-1:0]  last
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [DW-1:0] q, d;
    logic          upd;
    assign upd = cap_word && ((g == 0) || cap_long);
    always_comb begin
      d = q;
      if (clr)      d = '0;
      else if (upd) d = data_in[g*DW +: DW];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign words[g*DW +: DW] = q;
  end

  logic [LW-1:0] last_q, last_d;
  always_comb begin
    last_d = last_q;
    if (clr)           last_d = '0;
    else if (cap_last) last_d = last_in;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end
  assign last = last_q;
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_we,
  input  logic [REG_AW-1:0]         bus_addr,
  input  logic [WORD_W-1:0]         bus_wdata,
  output logic [WORD_W-1:0]         bus_rdata,
  output logic                      cmd_req_valid,
  input  logic                      cmd_req_ready,
  output logic [IDX_W-1:0]          cmd_req_index,
  output logic [WORD_W-1:0]         cmd_req_arg,
  output logic                      cmd_req_need_rsp,
  output logic                      cmd_req_long,
  output logic                      cmd_req_app,
  input  logic                      rsp_valid,
  input  logic [1:0]                rsp_code,
  input  logic [RSP_WORDS*WORD_W-1:0] rsp_data,
  output logic                      st_sent,
  output logic                      st_rsp_timeout,
  output logic                      st_rsp_crc_fail,
  output logic                      st_rsp_crc_ok
);
  localparam int LW = IDX_W + 1;

  logic        cmd_wr, arg_wr;
  cmd_fields_t fields;
  logic [WORD_W-1:0] arg;
  logic        go_bit, rst_busy, pending;
  logic        clr_all, cap_word, cap_long, cap_last;
  logic [RSP_WORDS*WORD_W-1:0] words;
  logic [LW-1:0] last;

  assign cmd_wr = bus_we && (bus_addr == REG_AW'(OFS_CMD));
  assign arg_wr = bus_we && (bus_addr == REG_AW'(OFS_ARG));

  sd_cmd_ctrl #(.RST_CYCLES(RST_CYCLES), .DW(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .arg_wr(arg_wr),
    .wdata(bus_wdata), .req_ready(cmd_req_ready), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .fields(fields), .arg(arg), .go_bit(go_bit),
    .rst_busy(rst_busy), .pending(pending), .req_valid(cmd_req_valid),
    .st_sent(st_sent), .st_to(st_rsp_timeout), .st_fail(st_rsp_crc_fail),
    .st_ok(st_rsp_crc_ok), .clr_all(clr_all), .cap_word(cap_word),
    .cap_long(cap_long), .cap_last(cap_last)
  );

  sd_rsp_store #(.DW(WORD_W), .NW(RSP_WORDS), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .cap_word(cap_word),
    .cap_long(cap_long), .cap_last(cap_last), .data_in(rsp_data),
    .last_in({fields.app, fields.idx}), .words(words), .last(last)
  );

  assign cmd_req_index    = fields.idx;
  assign cmd_req_arg      = arg;
  assign cmd_req_need_rsp = fields.need_rsp;
  assign cmd_req_long     = fields.long_rsp;
  assign cmd_req_app      = fields.app;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == REG_AW'(OFS_CMD)) begin
      bus_rdata[BIT_APP:0] = fields;
      bus_rdata[BIT_GO]    = go_bit;
      bus_rdata[BIT_RST]   = rst_busy;
    end
    if (bus_addr == REG_AW'(OFS_ARG))  bus_rdata = arg;
    if (bus_addr == REG_AW'(OFS_LAST)) bus_rdata[LW-1:0] = last;
    for (int i = 0; i < RSP_WORDS; i++) begin
      if (bus_addr == REG_AW'(OFS_RSP + 4 * i)) bus_rdata = words[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk
  import sd_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              pending,
  input logic              rst_busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IDX_W-1:0]  req_index,
  input logic [WORD_W-1:0] req_arg,
  input logic              req_need,
  input logic              req_long,
  input logic              req_app,
  input logic              sent,
  input logic              to,
  input logic              fail,
  input logic              ok
);
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == REG_AW'(OFS_CMD) && bus_wdata[BIT_GO] && !bus_wdata[BIT_RST] && !pending
    |=> req_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !(bus_we && bus_wdata[BIT_RST] && bus_addr == REG_AW'(OFS_CMD))
    |=> req_valid && $stable({req_index, req_arg, req_need, req_long, req_app}));

  a_r4_arg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pending && bus_we && bus_addr == REG_AW'(OFS_ARG) |=> $stable(req_arg));

  a_r5_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_need |=> sent && !to && !fail && !ok);

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({to, fail, ok}));

  a_r6_outcome_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (to || fail || ok) |-> sent);

  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> !req_valid && !sent && !to && !fail && !ok);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pending(pending), .rst_busy(rst_busy),
  .req_valid(cmd_req_valid), .req_ready(cmd_req_ready),
  .req_index(cmd_req_index), .req_arg(cmd_req_arg),
  .req_need(cmd_req_need_rsp), .req_long(cmd_req_long), .req_app(cmd_req_app),
  .sent(st_sent), .to(st_rsp_timeout), .fail(st_rsp_crc_fail), .ok(st_rsp_crc_ok)
);

// File: tb/tb_sd_cmd_issue.sv
module tb_sd_cmd_issue;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_we;
  logic [4:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         cmd_req_valid, cmd_req_ready;
  logic [5:0]   cmd_req_index;
  logic [31:0]  cmd_req_arg;
  logic         cmd_req_need_rsp, cmd_req_long, cmd_req_app;
  logic         rsp_valid;
  logic [1:0]   rsp_code;
  logic [127:0] rsp_data;
  logic         st_sent, st_rsp_timeout, st_rsp_crc_fail, st_rsp_crc_ok;

  int total = 0;
  int bad = 0;

  localparam logic [31:0] NEED = 32'h40, LONG = 32'h80, APP = 32'h100, GO = 32'h200, RST = 32'h400;
  localparam logic [31:0] L0 = 32'h1111_0000, L1 = 32'h2222_0001, L2 = 32'h3333_0002, L3 = 32'h4444_0003;

  always #10 clk = ~clk;

  sd_cmd_issue dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic accept();
    cmd_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_req_ready = 1'b0;
  endtask

  task automatic respond(input logic [1:0] code, input logic [127:0] data);
    rsp_valid = 1'b1; rsp_code = code; rsp_data = data;
    @(posedge clk); @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  function automatic logic [31:0] flags();
    return {28'd0, st_rsp_crc_ok, st_rsp_crc_fail, st_rsp_timeout, st_sent};
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    rd(0, d);  chk("R12 reset cmd", d, 0);
    rd(4, d);  chk("R12 reset arg", d, 0);
    rd(24, d); chk("R12 reset last", d, 0);
    chk("R12 reset flags", flags(), 0);
    chk("R12 reset valid", {31'd0, cmd_req_valid}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4, 32'hA5A5_1234); rd(4, d); chk("R1 arg readback", d, 32'hA5A5_1234);
    wr(0, 32'h5 | NEED | LONG | APP); rd(0, d); chk("R1 cmd readback", d, 32'h1C5);
    chk("R2 no start without go", {31'd0, cmd_req_valid}, 0);
  endtask

  task automatic t_long_ok();
    logic [31:0] d;
    wr(4, 32'h0000_0777);
    wr(0, 32'd2 | NEED | LONG | GO);
    chk("R2 valid", {31'd0, cmd_req_valid}, 1);
    chk("R2 index", {26'd0, cmd_req_index}, 2);
    chk("R2 arg", cmd_req_arg, 32'h777);
    chk("R2 quals", {29'd0, cmd_req_need_rsp, cmd_req_long, cmd_req_app}, 3'b110);
    rd(0, d); chk("R3 go bit while pending", {31'd0, d[9]}, 1);
    @(negedge clk);
    chk("R3 valid held", {31'd0, cmd_req_valid}, 1);
    wr(4, 32'hBAD0_BAD0); chk("R4 arg ignored", cmd_req_arg, 32'h777);
    wr(0, 32'd33 | GO);   chk("R4 cmd ignored", {26'd0, cmd_req_index}, 2);
    accept();
    chk("R3 valid dropped", {31'd0, cmd_req_valid}, 0);
    rd(0, d); chk("R3 go bit cleared", {31'd0, d[9]}, 0);
    respond(2'd0, {L3, L2, L1, L0});
    chk("R6 ok flags", flags(), 4'b1001);
    rd(8, d);  chk("R8 word0", d, L0);
    rd(12, d); chk("R8 word1", d, L1);
    rd(16, d); chk("R8 word2", d, L2);
    rd(20, d); chk("R8 word3", d, L3);
    rd(24, d); chk("R10 last long", d, 2);
  endtask

  task automatic t_short_ok();
    logic [31:0] d;
    wr(0, 32'd41 | NEED | APP | GO);
    accept();
    respond(2'd0, {32'h9, 32'h8, 32'h7, 32'hCAFE_0041});
    chk("R6 ok flags short", flags(), 4'b1001);
    rd(8, d);  chk("R7 word0 loaded", d, 32'hCAFE_0041);
    rd(12, d); chk("R7 word1 kept", d, L1);
    rd(20, d); chk("R7 word3 kept", d, L3);
    rd(24, d); chk("R10 last with app", d, 32'd41 | 32'h40);
  endtask

  task automatic t_crc_fail();
    logic [31:0] d;
    wr(0, 32'd9 | NEED | LONG | GO);
    accept();
    respond(2'd1, {4{32'hDEAD_DEAD}});
    chk("R6 fail flags", flags(), 4'b0101);
    rd(8, d);  chk("R9 word0 kept", d, 32'hCAFE_0041);
    rd(16, d); chk("R9 word2 kept", d, L2);
    rd(24, d); chk("R10 last on fail", d, 9);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    wr(0, 32'd12 | NEED | LONG | GO);
    chk("R11 flags cleared on start", flags(), 0);
    accept();
    respond(2'd2, {4{32'hBEEF_BEEF}});
    chk("R6 timeout flags", flags(), 4'b0011);
    rd(12, d); chk("R9 word1 kept", d, L1);
    rd(20, d); chk("R9 word3 kept", d, L3);
    rd(24, d); chk("R10 last kept on timeout", d, 9);
  endtask

  task automatic t_no_rsp();
    logic [31:0] d;
    wr(0, 32'd0 | GO);
    accept();
    chk("R5 sent only", flags(), 4'b0001);
    rd(8, d);  chk("R5 word0 kept", d, 32'hCAFE_0041);
    rd(20, d); chk("R5 word3 kept", d, L3);
  endtask

  task automatic t_ctrl_reset();
    logic [31:0] d;
    wr(4, 32'h1234_5678);
    wr(0, 32'd7 | NEED | GO);
    wr(0, RST);
    rd(0, d); chk("R12 busy bit", {31'd0, d[10]}, 1);
    chk("R12 request aborted", {31'd0, cmd_req_valid}, 0);
    wr(4, 32'hFFFF_0000);
    rd(0, d); chk("R12 busy bit cycle2", {31'd0, d[10]}, 1);
    @(negedge clk); @(negedge clk);
    rd(0, d); chk("R12 busy bit last cycle", {31'd0, d[10]}, 1);
    @(negedge clk);
    rd(0, d);  chk("R12 cmd cleared", d, 0);
    rd(4, d);  chk("R12 arg cleared, write ignored", d, 0);
    rd(8, d);  chk("R12 word0 cleared", d, 0);
    rd(20, d); chk("R12 word3 cleared", d, 0);
    rd(24, d); chk("R12 last cleared", d, 0);
    chk("R12 flags cleared", flags(), 0);
    wr(0, 32'd1 | GO);
    chk("R2 restart after reset", {31'd0, cmd_req_valid}, 1);
    accept();
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    cmd_req_ready = 1'b0; rsp_valid = 1'b0; rsp_code = '0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_regs();
    t_long_ok();
    t_short_ok();
    t_crc_fail();
    t_timeout();
    t_no_rsp();
    t_ctrl_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule